// File: doc/BRIEF.md
# Raw Entropy Sample Collector

This block gathers raw bits from a bank of 128 free-running oscillator outputs and packs them into 64-bit words. The words wait in a 64-word FIFO for a consumer to take them. The oscillators are split into 16 groups of eight, and only one group feeds the packer at a time. Every oscillator bit first passes through a two-flop synchronizer, and the packer then takes one 8-bit slice from the selected group on each clock. Eight such slices make one word. Whenever the FIFO has room the packer keeps running, so every word a consumer pops is soon replaced.

Software drives the unit through a small register port. Address 0 holds the control register, with a FIFO enable, an entropy enable, a raw-output enable, a group number and a pair of reset bits. Address 1 is a read-only self-test status register. When the entropy source is switched off but the FIFO is on, the oscillators are ignored. Words then come in from an external conditioning stage through a word-input port. A pop request returns one word a cycle later. A pop from an empty FIFO returns zero together with a one-cycle underflow pulse.

Top module: `entropy_harvest_fifo`

## Requirements
- R1: After reset, the control register reads zero and the FIFO is empty, so the first pop reports underflow.
- R2: A read at register address 1 (self-test status) always returns zero.
- R3: The group number is in control bits [7:4]. A value g selects the oscillators osc_in[8g+7:8g], and no other group reaches the output word.
- R4: Bit 8k+j of a raw word holds oscillator j of the selected group at sample k (k = 0..7). Sample 0 is in the least significant byte, and the eight samples come from consecutive clock cycles.
- R5: In raw mode, one word is completed every 8 clock cycles with no idle cycle between words while the FIFO has room.
- R6: Raw words are produced only when control bits 0 (FIFO enable), 1 (entropy enable) and 2 (raw enable) are all 1. With bit 0 = 1 and bits 1 and 2 = 0, the oscillators are ignored and each cond_valid word is stored in arrival order. Every other combination stores nothing.
- R7: The FIFO holds exactly 64 words in first-in first-out order. While it is full the packer stalls, and no stored word is lost or overwritten. Packing resumes as soon as a pop frees a slot.
- R8: A control write with bits 8 and 9 both set clears the whole control register, whatever the other bits hold, and empties the FIFO.
- R9: A control write that changes the group number discards the partial word, and packing restarts at sample 0 with the new group.
- R10: A pop returns its word with pop_valid one cycle after pop_req. A pop from an empty FIFO returns zero with pop_valid low and pop_underflow high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_in | input | 128 | Raw oscillator outputs, 8 per group |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 self-test status |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| cond_valid | input | 1 | Conditioned word present on cond_word |
| cond_word | input | 64 | Conditioned word from the external conditioner |
| pop_req | input | 1 | Request one word from the FIFO |
| pop_valid | output | 1 | pop_data carries a popped word |
| pop_data | output | 64 | Popped word, zero on underflow |
| pop_underflow | output | 1 | One-cycle pulse after a pop from an empty FIFO |

## Verification
The packer's push and the consumer's pop fall in the same cycle once the FIFO has drained below full while raw packing runs. The bench provokes this by popping every third cycle while a new word arrives every eighth. In raw mode, the selected oscillator group carries a running byte counter and every other group carries a different pattern. This lets each popped word be judged on its own: its bytes must rise by one from least to most significant. A word lost, duplicated or overwritten during a simultaneous push and pop breaks the byte run from one word to the next.

// File: rtl/esf_pkg.sv
package esf_pkg;

   localparam int REG_W = 64;

   // control register bit positions
   localparam int CTL_FIFO_EN = 0;
   localparam int CTL_ENT_EN  = 1;
   localparam int CTL_RAW_EN  = 2;
   localparam int CTL_GRP_LSB = 4;
   localparam int CTL_RST_LO  = 8;
   localparam int CTL_RST_HI  = 9;
   localparam int CTL_GRP_MAX = CTL_RST_LO - CTL_GRP_LSB;

   localparam logic ADDR_CTRL     = 1'b0;
   localparam logic ADDR_SELFTEST = 1'b1;

   typedef struct packed {
      logic raw_en;
      logic ent_en;
      logic fifo_en;
   } ctl_t;

   typedef enum logic [1:0] {
      SRC_IDLE = 2'd0,
      SRC_RAW  = 2'd1,
      SRC_COND = 2'd2
   } src_mode_e;

   function automatic src_mode_e pick_mode(input ctl_t c);
      if (c.fifo_en && c.ent_en && c.raw_en)
         return SRC_RAW;
      else if (c.fifo_en && !c.ent_en && !c.raw_en)
         return SRC_COND;
      else
         return SRC_IDLE;
   endfunction

endpackage

// File: rtl/esf_sync.sv
module esf_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   initial begin : p_param_chk
      assert (STAGES >= 0 && W >= 1) else $error("esf_sync: bad parameters");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_flops
      logic [STAGES-1:0][W-1:0] stg_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_q <= '0;
         end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++)
               stg_q[s] <= stg_q[s-1];
         end
      end

      assign q_o = stg_q[STAGES-1];
   end

endmodule

// File: rtl/esf_packer.sv
module esf_packer #(
   parameter int N_OSC  = 128,
   parameter int GRP_W  = 8,
   parameter int WORD_W = 64
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [N_OSC-1:0]                  osc_i,
   input  logic                              run_i,
   input  logic [$clog2(N_OSC/GRP_W)-1:0]    sel_i,
   input  logic                              restart_i,
   input  logic                              room_i,
   output logic                              push_o,
   output logic [WORD_W-1:0]                 word_o
);

   localparam int N_GRP   = N_OSC / GRP_W;
   localparam int SAMPLES = WORD_W / GRP_W;
   localparam int PH_W    = $clog2(SAMPLES);
   localparam int ACC_W   = WORD_W - GRP_W;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(SAMPLES - 1);

   initial begin : p_param_chk
      assert (N_OSC % GRP_W == 0) else $error("esf_packer: N_OSC not a multiple of GRP_W");
      assert (WORD_W % GRP_W == 0) else $error("esf_packer: WORD_W not a multiple of GRP_W");
      assert (SAMPLES >= 2 && (1 << PH_W) == SAMPLES) else $error("esf_packer: samples per word must be a power of two >= 2");
      assert ((1 << $clog2(N_GRP)) == N_GRP) else $error("esf_packer: group count must be a power of two");
   end

   // split the oscillator bank into selectable lanes
   logic [GRP_W-1:0] grp_bits [N_GRP];
   for (genvar g = 0; g < N_GRP; g++) begin : g_lane
      assign grp_bits[g] = osc_i[g*GRP_W +: GRP_W];
   end

   logic [GRP_W-1:0] lane;
   assign lane = grp_bits[sel_i];

   logic [PH_W-1:0]  phase_q;
   logic [ACC_W-1:0] acc_q;
   logic             step;

   assign step = run_i && room_i && !restart_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         acc_q   <= '0;
      end else if (restart_i || !run_i) begin
         phase_q <= '0;
      end else if (step) begin
         phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
         // shift right so the oldest sample ends in the low byte
         acc_q   <= {lane, acc_q[ACC_W-1:GRP_W]};
      end
   end

   assign push_o = step && (phase_q == PH_LAST);
   assign word_o = {lane, acc_q};

   AST_RAW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |=> !push_o) else $error("raw words closer than one per word time"); // R5

   AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (phase_q == '0)) else $error("partial word kept across group change"); // R9

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !room_i && !restart_i) |=> $stable(phase_q)) else $error("packer advanced while FIFO full"); // R7

endmodule

// File: rtl/esf_fifo.sv
module esf_fifo #(
   parameter int W     = 64,
   parameter int DEPTH = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush_i,
   input  logic         push_i,
   input  logic [W-1:0] push_data_i,
   input  logic         pop_i,
   output logic         full_o,
   output logic         empty_o,
   output logic         rd_valid_o,
   output logic [W-1:0] rd_data_o,
   output logic         uflow_o
);

   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

   initial begin : p_param_chk
      assert (DEPTH >= 2 && (1 << AW) == DEPTH) else $error("esf_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   cnt_q;
   logic          do_push, do_pop;

   assign full_o  = (cnt_q == CNT_FULL);
   assign empty_o = (cnt_q == '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;

   always_ff @(posedge clk) begin
      if (do_push)
         mem_q[wp_q] <= push_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush_i) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
         uflow_o    <= 1'b0;
      end else begin
         rd_valid_o <= do_pop;
         rd_data_o  <= do_pop ? mem_q[rp_q] : '0;
         uflow_o    <= pop_i && empty_o;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o) else $error("push offered to a full FIFO"); // R7

   AST_UFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty_o) |=> (uflow_o && !rd_valid_o && rd_data_o == '0)) else $error("empty pop not flagged"); // R10

   AST_UFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop_i && empty_o) |=> !uflow_o) else $error("spurious underflow"); // R10

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> empty_o) else $error("flush left words behind"); // R8

endmodule

// File: rtl/entropy_harvest_fifo.sv
module entropy_harvest_fifo
   import esf_pkg::*;
#(
   parameter int N_OSC       = 128,
   parameter int GRP_W       = 8,
   parameter int WORD_W      = 64,
   parameter int DEPTH       = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_OSC-1:0]  osc_in,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              cond_valid,
   input  logic [WORD_W-1:0] cond_word,
   input  logic              pop_req,
   output logic              pop_valid,
   output logic [WORD_W-1:0] pop_data,
   output logic              pop_underflow
);

   localparam int N_GRP = N_OSC / GRP_W;
   localparam int SEL_W = $clog2(N_GRP);

   initial begin : p_param_chk
      assert (SEL_W >= 1 && SEL_W <= CTL_GRP_MAX) else $error("entropy_harvest_fifo: group number does not fit its field");
   end

   // ---------------- control register ----------------
   ctl_t             ctl_q;
   logic [SEL_W-1:0] grp_q;
   logic             wr_ctl, rst_req, restart;
   logic [SEL_W-1:0] wr_grp;
   src_mode_e        mode;
   logic             unused_wdata;

   assign wr_ctl       = reg_wr && (reg_addr == ADDR_CTRL);
   assign rst_req      = wr_ctl && reg_wdata[CTL_RST_LO] && reg_wdata[CTL_RST_HI];
   assign wr_grp       = reg_wdata[CTL_GRP_LSB +: SEL_W];
   assign restart      = wr_ctl && (wr_grp != grp_q);
   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         grp_q <= '0;
      end else if (rst_req) begin
         ctl_q <= '0;
         grp_q <= '0;
      end else if (wr_ctl) begin
         ctl_q.fifo_en <= reg_wdata[CTL_FIFO_EN];
         ctl_q.ent_en  <= reg_wdata[CTL_ENT_EN];
         ctl_q.raw_en  <= reg_wdata[CTL_RAW_EN];
         grp_q         <= wr_grp;
      end
   end

   assign mode = pick_mode(ctl_q);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_CTRL) begin
         reg_rdata[CTL_FIFO_EN]             = ctl_q.fifo_en;
         reg_rdata[CTL_ENT_EN]              = ctl_q.ent_en;
         reg_rdata[CTL_RAW_EN]              = ctl_q.raw_en;
         reg_rdata[CTL_GRP_LSB +: SEL_W]    = grp_q;
      end
      // self-test status: no fault sources, reads as zero
   end

   // ---------------- datapath ----------------
   logic [N_OSC-1:0]  osc_sync;
   logic              full, empty;
   logic              pk_push, cond_push, fifo_push;
   logic [WORD_W-1:0] pk_word, fifo_wdata;

   esf_sync #(.W(N_OSC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (osc_in),
      .q_o   (osc_sync)
   );

   esf_packer #(.N_OSC(N_OSC), .GRP_W(GRP_W), .WORD_W(WORD_W)) u_packer (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc_i     (osc_sync),
      .run_i     (mode == SRC_RAW),
      .sel_i     (grp_q),
      .restart_i (restart),
      .room_i    (!full),
      .push_o    (pk_push),
      .word_o    (pk_word)
   );

   assign cond_push  = (mode == SRC_COND) && cond_valid && !full;
   assign fifo_push  = pk_push || cond_push;
   assign fifo_wdata = pk_push ? pk_word : cond_word;

   esf_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (rst_req),
      .push_i      (fifo_push),
      .push_data_i (fifo_wdata),
      .pop_i       (pop_req),
      .full_o      (full),
      .empty_o     (empty),
      .rd_valid_o  (pop_valid),
      .rd_data_o   (pop_data),
      .uflow_o     (pop_underflow)
   );

   AST_RAW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != SRC_RAW) |-> !pk_push) else $error("raw word outside raw mode"); // R6

   AST_COND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != SRC_COND) |-> !(fifo_push && !pk_push)) else $error("conditioned word outside its mode"); // R6

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> (ctl_q == '0 && grp_q == '0 && empty)) else $error("reset write incomplete"); // R8

endmodule

// File: tb/test_entropy_harvest_fifo.sv
`timescale 1ns/1ps
module test_entropy_harvest_fifo;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] osc_in = '0;
   logic         reg_wr = 1'b0;
   logic         reg_addr = 1'b0;
   logic [63:0]  reg_wdata = '0;
   logic [63:0]  reg_rdata;
   logic         cond_valid = 1'b0;
   logic [63:0]  cond_word = '0;
   logic         pop_req = 1'b0;
   logic         pop_valid;
   logic [63:0]  pop_data;
   logic         pop_underflow;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0]  tick = '0;
   int          hot_grp = 3;
   int          cst_grp = 13;
   bit          sb_on = 1'b0;
   logic [63:0] sb_q [$];

   always #2 clk = ~clk;   // 250 MHz

   entropy_harvest_fifo i_entropy_harvest_fifo (
      .clk           (clk),
      .rst_n         (rst_n),
      .osc_in        (osc_in),
      .reg_wr        (reg_wr),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .cond_valid    (cond_valid),
      .cond_word     (cond_word),
      .pop_req       (pop_req),
      .pop_valid     (pop_valid),
      .pop_data      (pop_data),
      .pop_underflow (pop_underflow)
   );

   // selected group counts up, a constant group reads A5, the rest count down
   function automatic logic [127:0] build_osc(input logic [7:0] t, input int hot, input int cst);
      logic [127:0] v;
      for (int g = 0; g < 16; g++) begin
         if (g == hot)      v[g*8 +: 8] = t;
         else if (g == cst) v[g*8 +: 8] = 8'hA5;
         else               v[g*8 +: 8] = ~t;
      end
      return v;
   endfunction

   always @(negedge clk) begin
      tick   = tick + 8'd1;
      osc_in = build_osc(tick, hot_grp, cst_grp);
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit rising_bytes(input logic [63:0] w);
      for (int k = 0; k < 7; k++)
         if (8'(w[8*(k+1) +: 8] - w[8*k +: 8]) != 8'd1) return 1'b0;
      return 1'b1;
   endfunction

   task automatic reg_write(input logic a, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
   endtask

   task automatic reg_read(input logic a, output logic [63:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
      reg_addr = 1'b0;
   endtask

   task automatic pop(output logic v, output logic [63:0] d, output logic uf);
      @(negedge clk);
      pop_req = 1'b1;
      @(negedge clk);
      pop_req = 1'b0;
      v = pop_valid; d = pop_data; uf = pop_underflow;
   endtask

   // driver: offer a conditioned word, optionally expecting it back
   task automatic send_cond(input logic [63:0] w, input bit expect_it);
      @(negedge clk);
      cond_valid = 1'b1; cond_word = w;
      if (expect_it) sb_q.push_back(w);
      @(negedge clk);
      cond_valid = 1'b0; cond_word = '0;
      repeat (80) @(negedge clk);
   endtask

   // monitor: compare every popped word against the scoreboard queue
   always @(negedge clk) begin
      if (sb_on && pop_valid) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R6 unexpected word", pop_data, 64'h0);
         end else begin
            logic [63:0] e;
            e = sb_q.pop_front();
            chk(pop_data == e, "R6 conditioned word order", pop_data, e);
         end
      end
   end

   task automatic expect_empty_pop(input string req);
      logic v; logic [63:0] d; logic uf;
      pop(v, d, uf);
      chk(uf == 1'b1 && v == 1'b0, {req, " underflow flag"}, {62'b0, v, uf}, 64'h1);
      chk(d == '0, {req, " underflow data"}, d, 64'h0);
      @(negedge clk);
      chk(pop_underflow == 1'b0, "R10 underflow lasts one cycle", {63'b0, pop_underflow}, 64'h0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] rd;
      logic        v, uf;
      logic [63:0] d, prev;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: reset state
      reg_read(1'b0, rd);
      chk(rd == '0, "R1 control after reset", rd, 64'h0);
      expect_empty_pop("R1");

      // R2: self-test status
      reg_read(1'b1, rd);
      chk(rd == '0, "R2 self-test status", rd, 64'h0);

      // R6: conditioned mode, oscillators ignored
      reg_write(1'b0, 64'h1);
      sb_on = 1'b1;
      send_cond(64'h0123_4567_89AB_CDEF, 1'b1);
      send_cond(64'hFEDC_BA98_7654_3210, 1'b1);
      send_cond(64'hDEAD_BEEF_0000_FFFF, 1'b1);
      send_cond(64'h5555_AAAA_5555_AAAA, 1'b1);
      repeat (4) pop(v, d, uf);
      @(negedge clk);
      chk(sb_q.size() == 0, "R6 all conditioned words returned", 64'(sb_q.size()), 64'h0);
      sb_on = 1'b0;
      expect_empty_pop("R6 no raw words in conditioned mode");

      // R6: FIFO+entropy without raw enable stores nothing, even offered words
      reg_write(1'b0, 64'h3);
      send_cond(64'h1111_2222_3333_4444, 1'b0);
      expect_empty_pop("R6 mode 0x3 idle");
      // R6: raw requested but FIFO disabled
      reg_write(1'b0, 64'h36);
      repeat (40) @(negedge clk);
      expect_empty_pop("R6 FIFO disabled");

      // R8: reset write clears control and drops stored words
      reg_write(1'b0, 64'h1);
      send_cond(64'hAAAA_0000_AAAA_0001, 1'b0);
      send_cond(64'hAAAA_0000_AAAA_0002, 1'b0);
      reg_write(1'b0, 64'h3F7);
      reg_read(1'b0, rd);
      chk(rd == '0, "R8 control cleared by reset write", rd, 64'h0);
      expect_empty_pop("R8 FIFO emptied");

      // R3 R4 R5 R7: raw mode on group 3, let the FIFO fill and stall
      hot_grp = 3; cst_grp = 13;
      reg_write(1'b0, 64'h37);
      reg_read(1'b0, rd);
      chk(rd == 64'h37, "R3 control readback", rd, 64'h37);
      repeat (600) @(negedge clk);
      prev = '0;
      for (int i = 0; i < 74; i++) begin
         pop(v, d, uf);
         @(negedge clk);
         chk(v == 1'b1, "R7 raw word available", {63'b0, v}, 64'h1);
         chk(rising_bytes(d), "R3 R4 group 3 bytes consecutive, sample 0 low", d, 64'h0);
         if (i >= 1 && i != 64)
            chk(8'(d[7:0] - prev[63:56]) == 8'd1, "R5 R7 no gap between words", d, prev);
         if (i == 64)
            chk(8'(d[7:0] - prev[63:56]) != 8'd1, "R7 stall after 64 words", d, prev);
         prev = d;
      end

      // R2 again with the unit running
      reg_read(1'b1, rd);
      chk(rd == '0, "R2 self-test while running", rd, 64'h0);

      // R9: change group mid-word, partial word must vanish
      reg_write(1'b0, 64'h300);
      reg_write(1'b0, 64'h37);
      repeat (3) @(negedge clk);
      reg_write(1'b0, 64'hD7);
      repeat (40) @(negedge clk);
      pop(v, d, uf);
      chk(v == 1'b1 && d == 64'hA5A5_A5A5_A5A5_A5A5, "R9 first word after group change", d, 64'hA5A5_A5A5_A5A5_A5A5);
      pop(v, d, uf);
      chk(d == 64'hA5A5_A5A5_A5A5_A5A5, "R3 group 13 selected", d, 64'hA5A5_A5A5_A5A5_A5A5);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule